// File: doc/BRIEF.md
# Weight Prefetch and Array Load Controller

This controller refills a local weight store while the compute array keeps working with the weights it already holds. A start command carries a source base address and a word count. The controller passes both to an external memory mover and then takes the returned 32-bit words from a valid/ready stream. It writes each word into the local weight SRAM at consecutive addresses from zero, and the processor never touches the data.

When the last word has arrived, the controller waits for the array to report that it is idle. It then locks the array, so that no convolution can be issued, and copies the words from the SRAM into the array one 32-bit write at a time. A one-cycle done pulse marks the end of the copy. A typical use is the weight swap between the fifth convolution/pooling stage of a network and the stages that follow it. The next layer's weights are fetched during the earlier convolutions, so only the copy adds latency.

The states are IDLE, FETCH, HOLD, COPY and FINISH. The transitions are:
- IDLE→FETCH on an accepted start.
- FETCH→HOLD when the last beat is accepted.
- HOLD→COPY when the array is idle.
- COPY→FINISH when the last array write is issued.
- FINISH→IDLE unconditionally.

Top module: `wf_load_ctrl`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `err_o`, `s_ready_o`, `arr_lock_o`, `arr_we_o` and `fetch_go_o` are all 0.
- R2: A start in IDLE with a length from 1 to DEPTH is accepted. In the next cycle `fetch_go_o` is 1 for exactly one cycle, with `fetch_base_o` and `fetch_len_o` equal to the command values, and `busy_o` is 1.
- R3: In FETCH, `s_ready_o` is 1. Each accepted beat writes `s_data_i` to the weight SRAM in the same cycle. The beat number n (counted from 0) goes to address n, and the write address does not advance on a cycle without a beat.
- R4: `s_ready_o` is 0 in every state except FETCH.
- R5: After the last beat, the controller waits in HOLD while `arr_idle_i` is 0, with `arr_lock_o` and `arr_we_o` both 0. It enters COPY in the cycle after it samples `arr_idle_i` as 1.
- R6: In COPY, the SRAM is read at addresses 0 to len-1 in order, with one-cycle read latency. Word k is written to array address k, with the data that was read from SRAM address k.
- R7: `arr_lock_o` is 1 for every cycle of COPY, which lasts exactly len+1 cycles, and `arr_we_o` is never 1 while `arr_lock_o` is 0.
- R8: `done_o` is 1 for exactly one cycle, directly after the last array write. In the following cycle `busy_o` is 0.
- R9: A start while `busy_o` is 1 raises `err_o` for one cycle and has no effect on the running transfer.
- R10: A start in IDLE with length 0 or greater than DEPTH raises `err_o` for one cycle, and the controller stays in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Prefetch command strobe |
| src_base_i | input | SRC_W | External source base address |
| len_i | input | LEN_W | Number of 32-bit words to load |
| fetch_go_o | output | 1 | One-cycle request to the external memory mover |
| fetch_base_o | output | SRC_W | Latched source base |
| fetch_len_o | output | LEN_W | Latched word count |
| s_valid_i | input | 1 | Stream beat valid |
| s_data_i | input | DW | Stream beat data |
| s_ready_o | output | 1 | Stream beat ready |
| wsram_we_o | output | 1 | Weight SRAM write enable |
| wsram_waddr_o | output | AW | Weight SRAM write address |
| wsram_wdata_o | output | DW | Weight SRAM write data |
| wsram_re_o | output | 1 | Weight SRAM read enable |
| wsram_raddr_o | output | AW | Weight SRAM read address |
| wsram_rdata_i | input | DW | Weight SRAM read data, one cycle after the read enable |
| arr_idle_i | input | 1 | Array has no convolution in flight |
| arr_lock_o | output | 1 | Blocks convolution issue while the copy runs |
| arr_we_o | output | 1 | Array weight write enable |
| arr_addr_o | output | AW | Array word address |
| arr_wdata_o | output | DW | Array write data |
| busy_o | output | 1 | Controller not in IDLE |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle rejected-command pulse |

## Verification
The bench covers the following corner cases and the failure each one would expose:
- Single-word and full-depth loads. A design with an off-by-one end test would drop or add an array write.
- Streams with gaps between beats. A design that advanced the SRAM address without a beat would leave holes in the stored weights.
- Array-idle delays of zero and several cycles. A design that started the copy early would lock or write the array while a convolution is still running.
- A start sent in the middle of a transfer, and starts with lengths of zero and of DEPTH+1. A design that accepted these would restart the fetch or load a bad count instead of flagging an error.

// File: rtl/wf_pkg.sv
package wf_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_FETCH  = 3'd1,
        ST_HOLD   = 3'd2,
        ST_COPY   = 3'd3,
        ST_FINISH = 3'd4
    } wf_state_t;
endpackage

// File: rtl/wf_fill.sv
module wf_fill #(
    parameter int AW = 14,
    parameter int DW = 32,
    parameter int LW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic [LW-1:0] len,
    input  logic          s_valid,
    input  logic [DW-1:0] s_data,
    output logic          s_ready,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [DW-1:0] wdata,
    output logic          last
);
    logic [AW-1:0] ptr_q;
    logic          beat;

    assign s_ready = en;
    assign beat    = en && s_valid;
    assign we      = beat;
    assign waddr   = ptr_q;
    assign wdata   = s_data;
    assign last    = beat && (LW'(ptr_q) == len - LW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    ptr_q <= '0;
        else if (clr)  ptr_q <= '0;
        else if (beat) ptr_q <= ptr_q + AW'(1);
    end

    assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!beat && !clr) |=> $stable(ptr_q));
endmodule

// File: rtl/wf_drain.sv
module wf_drain #(
    parameter int AW = 14,
    parameter int DW = 32,
    parameter int LW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic [LW-1:0] len,
    output logic          re,
    output logic [AW-1:0] raddr,
    input  logic [DW-1:0] rdata,
    output logic          arr_we,
    output logic [AW-1:0] arr_addr,
    output logic [DW-1:0] arr_wdata,
    output logic          finish
);
    logic [AW-1:0] rd_ptr_q;
    logic          rd_all_q;
    logic          we_q;
    logic [AW-1:0] addr_q;

    assign re        = en && !rd_all_q;
    assign raddr     = rd_ptr_q;
    assign arr_we    = we_q;
    assign arr_addr  = addr_q;
    assign arr_wdata = rdata;
    assign finish    = we_q && (LW'(addr_q) == len - LW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr_q <= '0;
            rd_all_q <= 1'b0;
            we_q     <= 1'b0;
            addr_q   <= '0;
        end else begin
            we_q   <= re;
            addr_q <= rd_ptr_q;
            if (clr) begin
                rd_ptr_q <= '0;
                rd_all_q <= 1'b0;
            end else if (re) begin
                if (LW'(rd_ptr_q) == len - LW'(1)) rd_all_q <= 1'b1;
                else                               rd_ptr_q <= rd_ptr_q + AW'(1);
            end
        end
    end

    assert_write_follows_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        re |=> (arr_we && arr_addr == $past(raddr)));
endmodule

// File: rtl/wf_load_ctrl.sv
module wf_load_ctrl
    import wf_pkg::*;
#(
    parameter int DEPTH = 16384,
    parameter int DW    = 32,
    parameter int SRC_W = 32,
    localparam int AW    = $clog2(DEPTH),
    localparam int LEN_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [SRC_W-1:0] src_base_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             fetch_go_o,
    output logic [SRC_W-1:0] fetch_base_o,
    output logic [LEN_W-1:0] fetch_len_o,
    input  logic             s_valid_i,
    input  logic [DW-1:0]    s_data_i,
    output logic             s_ready_o,
    output logic             wsram_we_o,
    output logic [AW-1:0]    wsram_waddr_o,
    output logic [DW-1:0]    wsram_wdata_o,
    output logic             wsram_re_o,
    output logic [AW-1:0]    wsram_raddr_o,
    input  logic [DW-1:0]    wsram_rdata_i,
    input  logic             arr_idle_i,
    output logic             arr_lock_o,
    output logic             arr_we_o,
    output logic [AW-1:0]    arr_addr_o,
    output logic [DW-1:0]    arr_wdata_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o
);
    wf_state_t        state_q, state_d;
    logic [LEN_W-1:0] len_q;
    logic [SRC_W-1:0] base_q;
    logic             go_q, err_q;
    logic             len_ok, start_ok;
    logic             fill_en, fill_last, copy_en, copy_finish;

    assign len_ok   = (len_i != '0) && (len_i <= LEN_W'(DEPTH));
    assign start_ok = start_i && (state_q == ST_IDLE) && len_ok;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_ok)    state_d = ST_FETCH;
            ST_FETCH:  if (fill_last)   state_d = ST_HOLD;
            ST_HOLD:   if (arr_idle_i)  state_d = ST_COPY;
            ST_COPY:   if (copy_finish) state_d = ST_FINISH;
            ST_FINISH:                  state_d = ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            len_q   <= '0;
            base_q  <= '0;
            go_q    <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            go_q    <= start_ok;
            err_q   <= start_i && !start_ok;
            if (start_ok) begin
                len_q  <= len_i;
                base_q <= src_base_i;
            end
        end
    end

    always_comb begin
        fill_en    = 1'b0;
        copy_en    = 1'b0;
        arr_lock_o = 1'b0;
        done_o     = 1'b0;
        busy_o     = 1'b1;
        unique case (state_q)
            ST_IDLE:   busy_o = 1'b0;
            ST_FETCH:  fill_en = 1'b1;
            ST_HOLD:   ;
            ST_COPY: begin
                copy_en    = 1'b1;
                arr_lock_o = 1'b1;
            end
            ST_FINISH: done_o = 1'b1;
            default:   busy_o = 1'b0;
        endcase
    end

    assign fetch_go_o   = go_q;
    assign fetch_base_o = base_q;
    assign fetch_len_o  = len_q;
    assign err_o        = err_q;

    wf_fill #(.AW(AW), .DW(DW), .LW(LEN_W)) i_fill (
        .clk(clk), .rst_n(rst_n), .clr(start_ok), .en(fill_en), .len(len_q),
        .s_valid(s_valid_i), .s_data(s_data_i), .s_ready(s_ready_o),
        .we(wsram_we_o), .waddr(wsram_waddr_o), .wdata(wsram_wdata_o),
        .last(fill_last)
    );

    wf_drain #(.AW(AW), .DW(DW), .LW(LEN_W)) i_drain (
        .clk(clk), .rst_n(rst_n), .clr(start_ok), .en(copy_en), .len(len_q),
        .re(wsram_re_o), .raddr(wsram_raddr_o), .rdata(wsram_rdata_i),
        .arr_we(arr_we_o), .arr_addr(arr_addr_o), .arr_wdata(arr_wdata_o),
        .finish(copy_finish)
    );

    assert_ready_fetch_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready_o |-> (busy_o && !arr_lock_o && !done_o));
    assert_copy_after_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arr_lock_o) |-> $past(arr_idle_i));
    assert_write_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we_o |-> arr_lock_o);
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));
    assert_busy_start_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy_o) |=> (err_o && !fetch_go_o));
endmodule

// File: tb/test_wf_load_ctrl.sv
module test_wf_load_ctrl;
    localparam int CLK_P = 10;
    localparam int DEPTH = 32;
    localparam int DW    = 32;
    localparam int SRC_W = 32;
    localparam int AW    = $clog2(DEPTH);
    localparam int LW    = $clog2(DEPTH + 1);

    localparam int NV = 4;
    localparam int          V_LEN  [NV] = '{1, 5, 32, 9};
    localparam int          V_GAP  [NV] = '{0, 2, 0, 3};
    localparam int          V_IDLE [NV] = '{0, 3, 1, 6};
    localparam logic [31:0] V_BASE [NV] = '{32'h1000_0000, 32'h2000_0040, 32'h3000_0100, 32'h4abc_0000};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [SRC_W-1:0] base = '0;
    logic [LW-1:0] len = '0;
    logic go, sready, swe, sre, idle, lock, awe, busy, done, err;
    logic svalid = 1'b0;
    logic [DW-1:0] sdata = '0;
    logic [SRC_W-1:0] gbase;
    logic [LW-1:0] glen;
    logic [AW-1:0] swa, sra, aaddr;
    logic [DW-1:0] swd, awd;
    logic [DW-1:0] srd = '0;

    logic [DW-1:0] smem [DEPTH];
    logic [DW-1:0] amem [DEPTH];
    int viol = 0;
    int order_err = 0;
    int arr_next = 0;
    int tests = 0;
    int fails = 0;

    always #(CLK_P/2) clk = ~clk;

    wf_load_ctrl #(.DEPTH(DEPTH), .DW(DW), .SRC_W(SRC_W)) i_wf_load_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start), .src_base_i(base), .len_i(len),
        .fetch_go_o(go), .fetch_base_o(gbase), .fetch_len_o(glen),
        .s_valid_i(svalid), .s_data_i(sdata), .s_ready_o(sready),
        .wsram_we_o(swe), .wsram_waddr_o(swa), .wsram_wdata_o(swd),
        .wsram_re_o(sre), .wsram_raddr_o(sra), .wsram_rdata_i(srd),
        .arr_idle_i(idle), .arr_lock_o(lock), .arr_we_o(awe), .arr_addr_o(aaddr),
        .arr_wdata_o(awd), .busy_o(busy), .done_o(done), .err_o(err)
    );

    always @(posedge clk) begin
        if (swe) smem[swa] <= swd;
        if (sre) srd <= smem[sra];
        if (go) arr_next <= 0;
        if (awe) begin
            amem[aaddr] <= awd;
            if (int'(aaddr) != arr_next) order_err <= order_err + 1;
            arr_next <= arr_next + 1;
            if (!lock) viol <= viol + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word(input int v, input int i);
        return V_BASE[v] ^ (32'h0101_0101 * (i + 1)) ^ 32'(v << 24);
    endfunction

    task automatic issue(input logic [31:0] b, input int l);
        @(negedge clk);
        start = 1'b1; base = b; len = LW'(l);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_vec(input int v);
        int l = V_LEN[v];
        int copy_cyc = 0;
        int done_cyc = 0;
        int wait_bad = 0;
        int sm_bad = 0;
        int am_bad = 0;
        idle = 1'b0;
        issue(V_BASE[v], l);
        check(go && gbase == V_BASE[v] && glen == LW'(l) && busy, "R2 fetch request", {31'd0, go}, 1);
        for (int i = 0; i < l; i++) begin
            if (V_GAP[v] != 0 && (i % V_GAP[v]) == 1) begin
                svalid = 1'b0;
                @(negedge clk);
            end
            svalid = 1'b1; sdata = word(v, i);
            if (i == l - 1 && V_IDLE[v] == 0) idle = 1'b1;
            @(negedge clk);
        end
        svalid = 1'b0;
        check(!sready, "R4 ready low after last beat", {31'd0, sready}, 0);
        for (int c = 0; c < V_IDLE[v]; c++) begin
            if (lock || awe || !busy || sready) wait_bad++;
            @(negedge clk);
        end
        check(wait_bad == 0, "R5 hold while array busy", wait_bad, 0);
        idle = 1'b1;
        @(negedge clk);
        for (int c = 0; c < 200 && !done; c++) begin
            if (lock) copy_cyc++;
            @(negedge clk);
        end
        check(done && !lock, "R8 done after copy", {31'd0, done}, 1);
        for (int i = 0; i < l; i++) begin
            if (smem[i] !== word(v, i)) sm_bad++;
            if (amem[i] !== word(v, i)) am_bad++;
        end
        check(sm_bad == 0, "R3 sram contents", sm_bad, 0);
        check(am_bad == 0 && order_err == 0, "R6 array contents and order", am_bad + order_err, 0);
        check(copy_cyc == l + 1 && viol == 0, "R7 copy length and lock", copy_cyc, l + 1);
        @(negedge clk);
        if (done) done_cyc++;
        check(done_cyc == 0 && !busy, "R8 single done pulse then idle", {30'd0, done, busy}, 0);
        idle = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        idle = 1'b0;
        repeat (3) @(negedge clk);
        check(!busy && !done && !err && !sready && !lock && !awe && !go, "R1 reset state",
              {25'd0, busy, done, err, sready, lock, awe, go}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int v = 0; v < NV; v++) run_vec(v);

        // R10 bad lengths
        issue(32'hdead_0000, 0);
        check(err && !busy && !go, "R10 zero length rejected", {30'd0, err, busy}, 2);
        @(negedge clk);
        check(!err, "R10 err single cycle", {31'd0, err}, 0);
        issue(32'hdead_0004, DEPTH + 1);
        check(err && !busy && !sready, "R10 oversize length rejected", {30'd0, err, busy}, 2);

        // R9 start while busy
        idle = 1'b1;
        issue(32'h5555_0000, 3);
        svalid = 1'b1; sdata = 32'h0000_aaaa;
        @(negedge clk);
        svalid = 1'b0;
        issue(32'h7777_0000, 20);
        check(err && !go && gbase == 32'h5555_0000 && glen == LW'(3), "R9 busy start rejected",
              gbase, 32'h5555_0000);
        svalid = 1'b1; sdata = 32'h0000_bbbb;
        @(negedge clk);
        sdata = 32'h0000_cccc;
        @(negedge clk);
        svalid = 1'b0;
        for (int c = 0; c < 20 && !done; c++) @(negedge clk);
        check(done && amem[0] == 32'h0000_aaaa && amem[2] == 32'h0000_cccc && smem[1] == 32'h0000_bbbb,
              "R9 running transfer unaffected", amem[2], 32'h0000_cccc);
        @(negedge clk);
        check(!busy && !sready, "R4 ready low in idle", {31'd0, sready}, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule